// File: doc/BRIEF.md
# Region-Timed Bus Access Wait-State Generator

This block times a single bus access on a 24-bit address bus. When a request is accepted it classifies the address by its bank (address bits 23:22) and page (address bits 15:8), together with a fast-ROM enable bit. From that it picks an access length of 6, 8 or 12 master clocks. DMA transfers bypass the region map and always last 4 master clocks. The block then steps through the access, 2 master clocks per clock cycle. It raises a data-sample strobe at the point where read data must be captured, and a done pulse when the access ends.

A bus master issues a request with `req_valid` while `busy` is low. It uses `sample_strobe` to capture read data and `done` to issue its next access. A new request may be presented in the same cycle that `done` is high. The running `mclk_count` gives a free timebase that moves only while an access is in progress, so it counts the master clocks spent on the bus.

Top module: `waitstate_gen`

## Requirements
- R1: While reset is asserted, and right after it is released, `busy`, `done`, `sample_strobe`, `access_mclks` and `mclk_count` are all zero.
- R2: Any address with bits 23:22 equal to 01 (banks 0x40 to 0x7F) gives an access length of 8, whatever the fast-ROM bit says.
- R3: An address with bits 23:22 equal to 11 (banks 0xC0 to 0xFF) gives 6 when fast-ROM is enabled at acceptance, and 8 otherwise.
- R4: When bits 23:22 are 00 or 10, the page in bits 15:8 selects the length: pages 0x00 to 0x1F give 8, pages 0x20 to 0x3F give 6, pages 0x40 and 0x41 give 12, pages 0x42 to 0x5F give 6, and pages 0x60 to 0x7F give 8.
- R5: Pages 0x80 to 0xFF give 8 when bits 23:22 are 00. When bits 23:22 are 10 they give 6 with fast-ROM enabled and 8 without it.
- R6: For a CPU read of length L, `sample_strobe` pulses for one cycle after (L-4)/2 steps, and `done` pulses after L/2 steps.
- R7: For a CPU write of length L, `done` pulses after L/2 steps and `sample_strobe` never rises.
- R8: When `req_dma` is set, `access_mclks` reads 4 and `done` comes after 2 steps, whatever the region. A DMA read strobes in the same cycle as `done`. A DMA write never strobes.
- R9: `mclk_count` rises by exactly 2 for each cycle spent in an access, holds while idle, and wraps modulo 2^MCLK_W.
- R10: A request presented while `busy` is high is ignored: `access_mclks` and the timing of `done` stay those of the running access. A request presented in the cycle where `done` is high is accepted.
- R11: `done` is high for exactly one cycle per access, and `busy` is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one step of 2 master clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken only when `busy` is low |
| req_addr | input | 24 | Access address; bank bits 23:22 and page bits 15:8 are used |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dma | input | 1 | 1 = DMA transfer with a fixed length |
| fast_rom_en | input | 1 | Fast-ROM enable, sampled at acceptance |
| busy | output | 1 | An access is in progress |
| access_mclks | output | 4 | Length in master clocks of the current or last access |
| sample_strobe | output | 1 | One-cycle pulse at which read data is captured |
| done | output | 1 | One-cycle pulse at the end of the access |
| mclk_count | output | MCLK_W (16) | Running master-clock count |

## Verification
The bench builds the block with MCLK_W set to 6, so the master-clock counter wraps after 32 steps. The vector walk therefore carries it across the wrap several times, and the modulo rule of R9 gets checked, not only plain increments. The length parameters stay at 6, 8, 12 and 4 with a read tail of 4. This puts every region class and the read split point of each length within reach of the vector table. The directed tests then cover a request held high through a busy access and a request accepted in the `done` cycle.

// File: rtl/waitstate_pkg.sv
package waitstate_pkg;

   typedef enum logic [1:0] {
      ACC_CPU_RD = 2'd0,
      ACC_CPU_WR = 2'd1,
      ACC_DMA_RD = 2'd2,
      ACC_DMA_WR = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      RGN_FAST  = 2'd0,
      RGN_SLOW  = 2'd1,
      RGN_XSLOW = 2'd2
   } rgn_class_e;

   function automatic acc_kind_e make_kind(input logic is_dma, input logic is_wr);
      acc_kind_e k;
      case ({is_dma, is_wr})
         2'b00:   k = ACC_CPU_RD;
         2'b01:   k = ACC_CPU_WR;
         2'b10:   k = ACC_DMA_RD;
         default: k = ACC_DMA_WR;
      endcase
      return k;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/waitstate_region_map.sv
module waitstate_region_map
   import waitstate_pkg::*;
(
   input  logic [1:0] bank_sel,
   input  logic [7:0] page,
   input  logic       fast_rom,
   output rgn_class_e rgn
);

   rgn_class_e rom_speed;

   always_comb begin
      rom_speed = fast_rom ? RGN_FAST : RGN_SLOW;
      case (bank_sel)
         2'd1: rgn = RGN_SLOW;
         2'd3: rgn = rom_speed;
         default: begin
            if (page < 8'h20)       rgn = RGN_SLOW;
            else if (page < 8'h40)  rgn = RGN_FAST;
            else if (page < 8'h42)  rgn = RGN_XSLOW;
            else if (page < 8'h60)  rgn = RGN_FAST;
            else if (page < 8'h80)  rgn = RGN_SLOW;
            else if (bank_sel == 2'd0) rgn = RGN_SLOW;
            else                    rgn = rom_speed;
         end
      endcase
   end

endmodule

// File: rtl/waitstate_step_timer.sv
module waitstate_step_timer
   import waitstate_pkg::*;
#(
   parameter int STEP_W     = 3,
   parameter int TAIL_STEPS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [STEP_W-1:0] start_steps,
   input  acc_kind_e         start_kind,
   output logic              busy,
   output logic              done,
   output logic              strobe
);

   localparam logic [STEP_W-1:0] LAST_STEP   = STEP_W'(1);
   localparam logic [STEP_W-1:0] SPLIT_STEP  = STEP_W'(TAIL_STEPS + 1);

   logic [STEP_W-1:0] left_q;
   acc_kind_e         kind_q;
   logic              busy_q, done_q, strobe_q;
   logic              at_last, at_split;

   assign at_last  = (left_q == LAST_STEP);
   assign at_split = (left_q == SPLIT_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q   <= '0;
         kind_q   <= ACC_CPU_RD;
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         strobe_q <= 1'b0;
      end else begin
         done_q   <= 1'b0;
         strobe_q <= 1'b0;
         if (busy_q) begin
            left_q   <= left_q - LAST_STEP;
            busy_q   <= !at_last;
            done_q   <= at_last;
            strobe_q <= ((kind_q == ACC_CPU_RD) && at_split) ||
                        ((kind_q == ACC_DMA_RD) && at_last);
         end else if (start) begin
            busy_q <= 1'b1;
            left_q <= start_steps;
            kind_q <= start_kind;
         end
      end
   end

   assign busy   = busy_q;
   assign done   = done_q;
   assign strobe = strobe_q;

   // R7
   wr_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_q |-> (kind_q == ACC_CPU_RD || kind_q == ACC_DMA_RD));

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);

endmodule

// File: rtl/waitstate_mclk_ctr.sv
module waitstate_mclk_ctr #(
   parameter int W    = 16,
   parameter int STEP = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] INC = W'(STEP);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (adv) cnt_q <= cnt_q + INC;
   end

   assign count = cnt_q;

   // R9
   mclk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> cnt_q == W'($past(cnt_q) + INC));

   // R9
   mclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(cnt_q));

endmodule

// File: rtl/waitstate_gen.sv
module waitstate_gen
   import waitstate_pkg::*;
#(
   parameter int MCLK_W      = 16,
   parameter int MCLK_STEP   = 2,
   parameter int FAST_MCLKS  = 6,
   parameter int SLOW_MCLKS  = 8,
   parameter int XSLOW_MCLKS = 12,
   parameter int DMA_MCLKS   = 4,
   parameter int TAIL_MCLKS  = 4,
   parameter int LEN_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [23:0]       req_addr,
   input  logic              req_write,
   input  logic              req_dma,
   input  logic              fast_rom_en,
   output logic              busy,
   output logic [LEN_W-1:0]  access_mclks,
   output logic              sample_strobe,
   output logic              done,
   output logic [MCLK_W-1:0] mclk_count
);

   localparam int MAX_MCLKS  = max3(FAST_MCLKS, SLOW_MCLKS, XSLOW_MCLKS) > DMA_MCLKS ?
                               max3(FAST_MCLKS, SLOW_MCLKS, XSLOW_MCLKS) : DMA_MCLKS;
   localparam int MIN_CPU    = (FAST_MCLKS < SLOW_MCLKS) ?
                               ((FAST_MCLKS < XSLOW_MCLKS) ? FAST_MCLKS : XSLOW_MCLKS) :
                               ((SLOW_MCLKS < XSLOW_MCLKS) ? SLOW_MCLKS : XSLOW_MCLKS);
   localparam int MAX_STEPS  = MAX_MCLKS / MCLK_STEP;
   localparam int STEP_W     = $clog2(MAX_STEPS + 1);
   localparam int TAIL_STEPS = TAIL_MCLKS / MCLK_STEP;

   generate
      if (MCLK_STEP < 1)
         begin : g_bad_step  $error("MCLK_STEP must be positive"); end
      if ((FAST_MCLKS % MCLK_STEP) != 0 || (SLOW_MCLKS % MCLK_STEP) != 0 ||
          (XSLOW_MCLKS % MCLK_STEP) != 0 || (DMA_MCLKS % MCLK_STEP) != 0 ||
          (TAIL_MCLKS % MCLK_STEP) != 0)
         begin : g_bad_div   $error("access lengths must be multiples of MCLK_STEP"); end
      if (MIN_CPU <= TAIL_MCLKS)
         begin : g_bad_tail  $error("every CPU length must exceed the read tail"); end
      if (DMA_MCLKS < MCLK_STEP)
         begin : g_bad_dma   $error("DMA length must cover at least one step"); end
      if ((1 << LEN_W) <= MAX_MCLKS)
         begin : g_bad_lenw  $error("LEN_W too narrow for the longest access"); end
      if (MCLK_W < $clog2(MCLK_STEP + 1))
         begin : g_bad_mclkw $error("MCLK_W too narrow for one step"); end
   endgenerate

   rgn_class_e         rgn;
   logic               accept;
   logic [LEN_W-1:0]   sel_mclks;
   logic [STEP_W-1:0]  sel_steps;
   logic [LEN_W-1:0]   len_q;
   logic               unused_addr_bits;

   assign unused_addr_bits = ^{req_addr[21:16], req_addr[7:0]};

   waitstate_region_map u_map (
      .bank_sel (req_addr[23:22]),
      .page     (req_addr[15:8]),
      .fast_rom (fast_rom_en),
      .rgn      (rgn)
   );

   always_comb begin
      if (req_dma) begin
         sel_mclks = LEN_W'(DMA_MCLKS);
      end else begin
         case (rgn)
            RGN_FAST:  sel_mclks = LEN_W'(FAST_MCLKS);
            RGN_XSLOW: sel_mclks = LEN_W'(XSLOW_MCLKS);
            default:   sel_mclks = LEN_W'(SLOW_MCLKS);
         endcase
      end
      sel_steps = STEP_W'(int'(sel_mclks) / MCLK_STEP);
   end

   assign accept = req_valid && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      len_q <= '0;
      else if (accept) len_q <= sel_mclks;
   end

   waitstate_step_timer #(
      .STEP_W     (STEP_W),
      .TAIL_STEPS (TAIL_STEPS)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept),
      .start_steps (sel_steps),
      .start_kind  (make_kind(req_dma, req_write)),
      .busy        (busy),
      .done        (done),
      .strobe      (sample_strobe)
   );

   waitstate_mclk_ctr #(
      .W    (MCLK_W),
      .STEP (MCLK_STEP)
   ) u_mclk (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (busy),
      .count (mclk_count)
   );

   assign access_mclks = len_q;

   // R10
   hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(access_mclks));

   // R2
   len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (access_mclks == LEN_W'(FAST_MCLKS) || access_mclks == LEN_W'(SLOW_MCLKS) ||
                access_mclks == LEN_W'(XSLOW_MCLKS) || access_mclks == LEN_W'(DMA_MCLKS)));

   // R10
   accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

endmodule

// File: tb/waitstate_gen_tb_top.sv
`timescale 1ns/1ps
module waitstate_gen_tb_top;

   localparam int MW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [23:0]   req_addr = '0;
   logic          req_write = 1'b0;
   logic          req_dma = 1'b0;
   logic          fast_rom_en = 1'b0;
   logic          busy;
   logic [3:0]    access_mclks;
   logic          sample_strobe;
   logic          done;
   logic [MW-1:0] mclk_count;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   waitstate_gen #(.MCLK_W(MW)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_addr      (req_addr),
      .req_write     (req_write),
      .req_dma       (req_dma),
      .fast_rom_en   (fast_rom_en),
      .busy          (busy),
      .access_mclks  (access_mclks),
      .sample_strobe (sample_strobe),
      .done          (done),
      .mclk_count    (mclk_count)
   );

   // fields: {addr[23:0], fast_rom, expected length[3:0], requirement number[3:0]}
   // R2 banks 40-7F, R3 banks C0-FF, R4 low-page map, R5 high pages
   localparam int NV = 14;
   localparam logic [32:0] VECS [NV] = '{
      {24'h7E1234, 1'b0, 4'd8,  4'd2},
      {24'h401FFF, 1'b1, 4'd8,  4'd2},
      {24'hC08000, 1'b1, 4'd6,  4'd3},
      {24'hFF0000, 1'b0, 4'd8,  4'd3},
      {24'h001FFF, 1'b1, 4'd8,  4'd4},
      {24'h002100, 1'b0, 4'd6,  4'd4},
      {24'h804016, 1'b0, 4'd12, 4'd4},
      {24'h004100, 1'b1, 4'd12, 4'd4},
      {24'h005FFF, 1'b0, 4'd6,  4'd4},
      {24'h806000, 1'b1, 4'd8,  4'd4},
      {24'h3F4200, 1'b0, 4'd6,  4'd4},
      {24'h3F8000, 1'b1, 4'd8,  4'd5},
      {24'h80FFFF, 1'b1, 4'd6,  4'd5},
      {24'hBF8000, 1'b0, 4'd8,  4'd5}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // wait for done; c = step at which done seen, s = last step at which strobe seen
   task automatic wait_done(output int c, output int s);
      c = 0; s = 0;
      while (!done && c < 40) begin
         @(negedge clk);
         c++;
         if (sample_strobe) s = c;
      end
   endtask

   task automatic launch(input logic [23:0] a, input logic wr, input logic dma, input logic fr);
      @(negedge clk);
      req_addr = a; req_write = wr; req_dma = dma; fast_rom_en = fr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic run_access(input logic [23:0] a, input logic wr, input logic dma,
                             input logic fr, input int len, input string rq);
      int c, s, m0, exp_s;
      launch(a, wr, dma, fr);
      m0 = int'(mclk_count);
      check({rq, " busy after accept"}, int'(busy), 1);
      check({rq, " access length"}, int'(access_mclks), len);
      wait_done(c, s);
      check({rq, " done step"}, c, len / 2);
      if (dma)     exp_s = wr ? 0 : 2;
      else if (wr) exp_s = 0;
      else         exp_s = (len - 4) / 2;
      check({rq, " strobe step"}, s, exp_s);
      check("R9 mclk advance", int'(mclk_count), (m0 + len) % (1 << MW));
      check("R11 busy low at done", int'(busy), 0);
      @(negedge clk);
      check("R11 done single cycle", int'(done), 0);
   endtask

   initial begin
      int c, s, m;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 busy", int'(busy), 0);
      check("R1 done", int'(done), 0);
      check("R1 strobe", int'(sample_strobe), 0);
      check("R1 len", int'(access_mclks), 0);
      check("R1 mclk", int'(mclk_count), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 mclk after release", int'(mclk_count), 0);

      for (int i = 0; i < NV; i++) begin
         run_access(VECS[i][32:9], 1'b0, 1'b0, VECS[i][8], int'(VECS[i][7:4]),
                    $sformatf("R%0d", int'(VECS[i][3:0])));
      end

      // R6 reads of every length
      run_access(24'h002000, 1'b0, 1'b0, 1'b0, 6, "R6");
      run_access(24'h000000, 1'b0, 1'b0, 1'b0, 8, "R6");
      run_access(24'h004000, 1'b0, 1'b0, 1'b1, 12, "R6");
      // R7 writes
      run_access(24'h004000, 1'b1, 1'b0, 1'b0, 12, "R7");
      run_access(24'hC00000, 1'b1, 1'b0, 1'b1, 6, "R7");
      // R8 DMA ignores region
      run_access(24'h004100, 1'b0, 1'b1, 1'b0, 4, "R8");
      run_access(24'h7F0000, 1'b1, 1'b1, 1'b1, 4, "R8");

      // R9 idle hold
      m = int'(mclk_count);
      repeat (4) @(negedge clk);
      check("R9 idle hold", int'(mclk_count), m);

      // R10 request held during busy is ignored
      @(negedge clk);
      req_addr = 24'h004000; req_write = 1'b1; req_dma = 1'b0; fast_rom_en = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_addr = 24'hC08000; req_dma = 1'b1; fast_rom_en = 1'b1;
      c = 0;
      while (!done && c < 40) begin
         @(negedge clk);
         c++;
         if (!done) check("R10 length held", int'(access_mclks), 12);
      end
      req_valid = 1'b0;
      check("R10 done step unchanged", c, 6);
      check("R10 length at done", int'(access_mclks), 12);
      @(negedge clk);
      check("R10 busy request not taken", int'(busy), 0);

      // R10 request in done cycle is accepted
      @(negedge clk);
      req_addr = 24'h002000; req_write = 1'b0; req_dma = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done(c, s);
      check("R10 first access done", c, 3);
      req_addr = 24'h7E0000; req_write = 1'b1; req_dma = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 accepted in done cycle", int'(busy), 1);
      check("R8 dma length", int'(access_mclks), 4);
      wait_done(c, s);
      check("R8 dma write done step", c, 2);
      check("R8 dma write no strobe", s, 0);

      // R1 reset in the middle of an access
      launch(24'h004000, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 busy mid reset", int'(busy), 0);
      check("R1 mclk mid reset", int'(mclk_count), 0);
      check("R1 len mid reset", int'(access_mclks), 0);
      finished = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!finished && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=finish", cyc);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule